// File: doc/BRIEF.md
# Comparator Hit Detection Array

This block turns the raw, asynchronous outputs of a bank of per-channel discriminators into one registered hit bit per channel on every clock. The hit vector goes straight into a pipeline memory that is written on every cycle. A single global mode input chooses how each discriminator output is conditioned.

In follow mode, each channel's level passes through a synchroniser and then appears at the output. A pulse that rises and falls between two clock edges is never sampled, so it is lost. In one-shot mode, an edge-triggered capture cell, clocked by the discriminator itself, catches every rising edge, including pulses much shorter than a clock period. The captured event is then synchronised and emitted as a hit exactly one cycle wide, however long the pulse was. The capture cell is cleared after it has been sampled. A level that stays high after its hit cannot raise another hit until it falls and rises again.

The output has no valid/ready handshake. The pipeline accepts a full vector on every cycle, so back-pressure never occurs and every cycle's vector is meaningful. The mode select and reset are plain control pins.

Top module: `hit_det_array`

## Requirements
- R1: While reset is low, and for the first three rising clock edges after reset is released, `hit_o` is all zeros, whatever `comp_i` does.
- R2: With `mode_i` = 1 (follow), a level on `comp_i` that is stable across the sampling edges appears on `hit_o` after exactly three rising clock edges and stays there while the level is held.
- R3: With `mode_i` = 1, a pulse that rises and falls between two consecutive rising clock edges produces no hit on any cycle.
- R4: With `mode_i` = 0 (one-shot), a pulse shorter than one clock period produces a hit on its channel for exactly one cycle. The hit starts after the third rising edge that follows the pulse's rising edge.
- R5: With `mode_i` = 0, a pulse held high for many cycles produces exactly one hit cycle, with the same three-edge latency as R4.
- R6: With `mode_i` = 0, after an input falls and has been low for at least six cycles, a new rising edge on it produces a new one-cycle hit.
- R7: Channels are independent. A pulse on one channel sets only that channel's bit of `hit_o`, and bit i of `hit_o` belongs to bit i of `comp_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; the pipeline is written on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; also clears every capture cell |
| mode_i | input | 1 | 1 = follow synchronised level, 0 = one-cycle hit per rising edge |
| comp_i | input | N_CH (128) | Raw asynchronous discriminator outputs, one per channel |
| hit_o | output | N_CH (128) | Registered hit vector, one bit per channel |

## Verification
The hardest case to produce is a discriminator pulse that starts and ends entirely between two sampling edges. It must be caught by the capture cell in one-shot mode and missed in follow mode. The bench drives such pulses with sub-nanosecond delays after a falling clock edge, so both edges of the pulse land inside the low half of the clock. It also holds an input high for many cycles and then re-arms it. This exercises the clear path of the capture cell, which no clock-aligned stimulus can separate from a plain synchroniser.

// File: rtl/hit_det_pkg.sv
package hit_det_pkg;
  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_FOLLOW  = 1'b1
  } hit_mode_e;

  localparam int unsigned DEF_CHANNELS    = 128;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/hit_det_sync.sv
module hit_det_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/hit_det_edge_latch.sv
module hit_det_edge_latch (
  input  logic trig,
  input  logic clr,
  output logic caught
);
  // Set by the discriminator's own rising edge; cleared asynchronously.
  always_ff @(posedge trig or posedge clr) begin
    if (clr) caught <= 1'b0;
    else     caught <= 1'b1;
  end
endmodule

// File: rtl/hit_det_chan.sv
module hit_det_chan #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic follow,
  input  logic comp,
  output logic hit
);
  logic caught;
  logic caught_s;
  logic caught_d;
  logic level_s;
  logic clr_any;

  // The capture cell stays cleared while its event is being consumed.
  assign clr_any = ~rst_n | caught_d;

  hit_det_edge_latch u_cap (
    .trig   (comp),
    .clr    (clr_any),
    .caught (caught)
  );

  hit_det_sync #(.STAGES(SYNC_STAGES)) u_sync_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (caught),
    .q     (caught_s)
  );

  hit_det_sync #(.STAGES(SYNC_STAGES)) u_sync_lvl (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (comp),
    .q     (level_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caught_d <= 1'b0;
      hit      <= 1'b0;
    end else begin
      caught_d <= caught_s;
      hit      <= follow ? level_s : (caught_s & ~caught_d);
    end
  end
endmodule

// File: rtl/hit_det_array.sv
module hit_det_array
  import hit_det_pkg::*;
#(
  parameter int unsigned N_CH        = DEF_CHANNELS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_i,
  input  logic [N_CH-1:0] comp_i,
  output logic [N_CH-1:0] hit_o
);
  logic follow;
  assign follow = (hit_mode_e'(mode_i) == MODE_FOLLOW);

  generate
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      hit_det_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
        .clk    (clk),
        .rst_n  (rst_n),
        .follow (follow),
        .comp   (comp_i[ch]),
        .hit    (hit_o[ch])
      );
    end
  endgenerate
endmodule

// File: rtl/hit_det_chk.sv
module hit_det_chk #(
  parameter int unsigned N_CH        = 128,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_i,
  input logic [N_CH-1:0] comp_i,
  input logic [N_CH-1:0] hit_o
);
  localparam int unsigned LAT = SYNC_STAGES + 1;

  logic [N_CH-1:0] hist [LAT];
  logic [7:0]      since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      for (int k = 0; k < LAT; k++) hist[k] <= '0;
    end else begin
      if (since_rst != 8'hFF) since_rst <= since_rst + 8'd1;
      hist[0] <= comp_i;
      for (int k = 1; k < LAT; k++) hist[k] <= hist[k-1];
    end
  end

  // R1: output idle while reset is held
  always @(negedge clk) begin
    if (!rst_n) a_r1_idle_in_reset: assert (hit_o == '0);
  end

  // R1: nothing can emerge before the latency has elapsed
  a_r1_quiet_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 8'(LAT)) |-> (hit_o == '0));

  // R2: follow mode reproduces the sampled level LAT edges later
  a_r2_follow_level: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 8'(LAT)) && $past(mode_i)) |-> (hit_o == hist[LAT-1]));

  // R4/R5: one-shot hits never last two cycles
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_rst >= 8'd2) && !$past(mode_i) && !$past(mode_i, 2))
      |-> ((hit_o & $past(hit_o)) == '0));
endmodule

bind hit_det_array hit_det_chk #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode_i (mode_i),
  .comp_i (comp_i),
  .hit_o  (hit_o)
);

// File: tb/hit_det_array_tb_top.sv
`timescale 1ns/1ps
module hit_det_array_tb_top;
  localparam int NC = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b1;
  logic [NC-1:0] comp = '0;
  logic [NC-1:0] hit;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hit_det_array dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode),
    .comp_i (comp),
    .hit_o  (hit)
  );

  typedef struct packed {
    logic        md;
    logic [15:0] seed;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 16'hA5C3}, '{1'b1, 16'h0001}, '{1'b1, 16'hFFFF}, '{1'b1, 16'h0000},
    '{1'b0, 16'h8000}, '{1'b0, 16'h5A5A}, '{1'b0, 16'hFFFF}, '{1'b0, 16'h0F0F}
  };

  task automatic chk(input bit ok, input string req,
                     input logic [NC-1:0] act, input logic [NC-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input logic md, input int n);
    @(negedge clk);
    comp = '0;
    mode = md;
    repeat (n) @(negedge clk);
  endtask

  // Sub-cycle pulse placed entirely inside the low half of the clock
  task automatic short_pulse(input logic [NC-1:0] pat);
    @(negedge clk);
    #0.5 comp = pat;
    #1.0 comp = '0;
  endtask

  initial begin
    // R1: reset behaviour with a busy input
    repeat (2) @(negedge clk);
    comp = '1;
    @(negedge clk);
    chk(hit == '0, "R1 in reset", hit, '0);
    short_pulse({NC{1'b1}});
    @(negedge clk);
    chk(hit == '0, "R1 in reset after pulse", hit, '0);
    comp = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(hit == '0, "R1 after release", hit, '0);
    settle(1'b1, 4);

    // Table walk: R2 levels and R4 short pulses
    foreach (VECS[i]) begin
      logic [NC-1:0] pat;
      pat = {8{VECS[i].seed}};
      if (VECS[i].md) begin
        if (mode != 1'b1) settle(1'b1, 8);
        @(negedge clk);
        comp = pat;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(hit == pat, "R2 level after three edges", hit, pat);
        @(negedge clk);
        chk(hit == pat, "R2 level held", hit, pat);
      end else begin
        settle(1'b0, 8);
        short_pulse(pat);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(hit == pat, "R4 one-shot hit", hit, pat);
        @(negedge clk);
        chk(hit == '0, "R4 hit lasts one cycle", hit, '0);
      end
    end

    // R3: follow mode misses a pulse between edges
    settle(1'b1, 8);
    short_pulse({NC{1'b1}});
    begin
      bit seen = 1'b0;
      logic [NC-1:0] any = '0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        any |= hit;
        if (hit != '0) seen = 1'b1;
      end
      chk(!seen, "R3 short pulse dropped in follow mode", any, '0);
    end

    // R5 and R6: long pulse, one hit, then re-arm
    settle(1'b0, 8);
    begin
      logic [NC-1:0] pat = {8{16'h3C96}};
      int hits = 0;
      int bad = 0;
      @(negedge clk);
      comp = pat;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(hit == pat, "R5 long pulse hit timing", hit, pat);
      for (int c = 0; c < 14; c++) begin
        if (hit == pat) hits++;
        else if (hit != '0) bad++;
        @(negedge clk);
      end
      chk(hits == 1 && bad == 0, "R5 single hit for long pulse",
          NC'(hits), NC'(1));
      comp = '0;
      repeat (7) @(negedge clk);
      chk(hit == '0, "R6 idle after fall", hit, '0);
      comp = pat;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(hit == pat, "R6 re-armed hit", hit, pat);
      @(negedge clk);
      chk(hit == '0, "R6 re-armed hit one cycle", hit, '0);
    end

    // R7: isolation of a single channel in both modes
    settle(1'b0, 8);
    begin
      logic [NC-1:0] one = '0;
      one[77] = 1'b1;
      short_pulse(one);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(hit == one, "R7 single channel one-shot", hit, one);
      settle(1'b1, 8);
      one = '0;
      one[0] = 1'b1;
      one[NC-1] = 1'b1;
      comp = one;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(hit == one, "R7 edge channels follow", hit, one);
    end

    settle(1'b1, 4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule